// File: doc/BRIEF.md
# Multi-Channel Compare Match Timer

This block holds several independent up-counting timer channels behind one small word-addressed register port. Each channel has a 32-bit counter, a 32-bit compare register and a control/status word. All channels share one start register, with one run bit per channel. Software loads a stopped channel's counter, compare value and configuration, then sets its run bit. The counter then steps once every 4, 8, 16 or 64 clocks.

When a step finds the counter equal to the compare value, the counter returns to zero and the channel's match flag is set. A compare value of all ones also sets an overflow flag. In one-shot mode the channel then stops. In periodic mode it keeps counting. Each channel drives an interrupt line from its match flag and an enable bit. A flag is cleared by a write of 0 that follows a read in which the flag was seen as 1.

Address map (word addresses): 0 is the start register, with bit c belonging to channel c. Channel c uses address 4c+4 for its control/status word, 4c+5 for its counter and 4c+6 for its compare register. All other addresses read as 0.

The control/status word has these fields:
- bit 0: match flag
- bit 1: overflow flag
- bit 2: mode (0 is one-shot, 1 is periodic)
- bit 3: interrupt enable
- bits 5:4: divider select

Top module: `match_timer`

## Requirements
- R1: A channel's counter stays at its loaded value until a write of 1 to that channel's bit in the start register (address 0).
- R2: While running, the counter advances once every D clocks, where divider select (bits 5:4) values 0, 1, 2 and 3 give D = 4, 8, 16 and 64. The first advance lands D clock edges after the edge that wrote the start bit.
- R3: With mode bit 2 = 0 (one-shot), the step that finds counter equal to compare clears the counter, sets the match flag (bit 0) and clears the channel's start bit. The counter then stays at 0.
- R4: With mode bit 2 = 1 (periodic), the step that finds counter equal to compare clears the counter, sets the match flag and leaves the channel running.
- R5: A match with compare equal to 0xFFFFFFFF sets both the match flag (bit 0) and the overflow flag (bit 1).
- R6: A write to the control word with a flag bit at 0 clears that flag only if a read (rdEn) of the control word saw the flag at 1 since the last control write. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R7: If a match and a valid flag clear land on the same clock edge, the match flag ends up set.
- R8: irq[c] is high exactly when channel c's match flag and its interrupt enable (bit 3) are both 1.
- R9: Clearing a start bit stops the counter, and the counter keeps its current value.
- R10: While a channel's start bit is 1, writes to its counter, its compare register and its mode, enable and divider fields are ignored. Flag clears still take effect.
- R11: After reset, the start register, counters, flags and configuration fields are 0, compare registers are 0xFFFFFFFF and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | AW | Word address |
| wrData | input | W | Write data |
| rdData | output | W | Read data, combinational from addr |
| irq | output | NCH | Per-channel interrupt |

## Verification
A software clear of the match flag and a new hardware match can arrive on the same clock edge. The bench runs a periodic channel with compare value 0 at divide-by-4, so a match lands every fourth edge. It arms the clear with a read, then times the clearing write to hit exactly one of those match edges, and expects the flag to stay set. A second armed clear is placed two edges later, off a match edge, and must leave the flag at 0. Together the two show that the clear itself works and that the match takes priority over it.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic       run;
    logic       cntLoad;
    logic       cmpLoad;
    logic [1:0] divSel;
  } chanCmd_t;

  localparam int BIT_FLAG = 0;
  localparam int BIT_OVF  = 1;
  localparam int BIT_MODE = 2;
  localparam int BIT_IEN  = 3;
  localparam int BIT_DIV  = 4;
  localparam int CTRL_W   = 6;
endpackage

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCmd_t [NCH-1:0]    cmd,
  input  logic [W-1:0]          wrData,
  output logic [NCH-1:0][W-1:0] cntVal,
  output logic [NCH-1:0][W-1:0] cmpVal,
  output logic [NCH-1:0]        hit,
  output logic [NCH-1:0]        hitOvf
);
  localparam int PW = 6;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [PW-1:0] presc;
    logic [PW-1:0] limit;
    logic          tick;

    always_comb begin
      case (cmd[c].divSel)
        2'd0:    limit = PW'(3);
        2'd1:    limit = PW'(7);
        2'd2:    limit = PW'(15);
        default: limit = PW'(63);
      endcase
    end

    assign tick      = cmd[c].run && (presc == limit);
    assign hit[c]    = tick && (cntVal[c] == cmpVal[c]);
    assign hitOvf[c] = hit[c] && (&cmpVal[c]);

    always_ff @(posedge clk) begin
      if (!rstN || !cmd[c].run) presc <= '0;
      else if (presc == limit)  presc <= '0;
      else                      presc <= presc + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)               cntVal[c] <= '0;
      else if (cmd[c].cntLoad) cntVal[c] <= wrData;
      else if (hit[c])         cntVal[c] <= '0;
      else if (tick)           cntVal[c] <= cntVal[c] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)               cmpVal[c] <= '1;
      else if (cmd[c].cmpLoad) cmpVal[c] <= wrData;
    end
  end
endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 32,
  parameter int AW  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          wrData,
  input  logic [NCH-1:0]        hit,
  input  logic [NCH-1:0]        hitOvf,
  input  logic [NCH-1:0][W-1:0] cntVal,
  input  logic [NCH-1:0][W-1:0] cmpVal,
  output chanCmd_t [NCH-1:0]    cmd,
  output logic [W-1:0]          rdData,
  output logic [NCH-1:0]        irq,
  output logic [NCH-1:0]        runBits,
  output logic [NCH-1:0]        modeBits,
  output logic [NCH-1:0]        matchFlag,
  output logic [NCH-1:0]        ovfFlag
);
  logic                        startWr;
  logic [NCH-1:0]              intEn;
  logic [NCH-1:0][1:0]         divSel;
  logic [NCH-1:0][CTRL_W-1:0]  ctrlWord;

  assign startWr = wrEn && (addr == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [AW-1:0] A_CTRL = AW'(4*c + 4);
    localparam logic [AW-1:0] A_CNT  = AW'(4*c + 5);
    localparam logic [AW-1:0] A_CMP  = AW'(4*c + 6);

    logic ctrlWr, ctrlRd, armMatch, armOvf;
    assign ctrlWr = wrEn && (addr == A_CTRL);
    assign ctrlRd = rdEn && (addr == A_CTRL);

    always_ff @(posedge clk) begin
      if (!rstN)                        runBits[c] <= 1'b0;
      else if (startWr)                 runBits[c] <= wrData[c];
      else if (hit[c] && !modeBits[c])  runBits[c] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeBits[c] <= 1'b0;
        intEn[c]    <= 1'b0;
        divSel[c]   <= 2'd0;
      end else if (ctrlWr && !runBits[c]) begin
        modeBits[c] <= wrData[BIT_MODE];
        intEn[c]    <= wrData[BIT_IEN];
        divSel[c]   <= wrData[BIT_DIV +: 2];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        armMatch <= 1'b0;
        armOvf   <= 1'b0;
      end else if (ctrlWr) begin
        armMatch <= 1'b0;
        armOvf   <= 1'b0;
      end else if (ctrlRd) begin
        armMatch <= armMatch | matchFlag[c];
        armOvf   <= armOvf | ovfFlag[c];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                        matchFlag[c] <= 1'b0;
      else if (hit[c])                                  matchFlag[c] <= 1'b1;
      else if (ctrlWr && armMatch && !wrData[BIT_FLAG]) matchFlag[c] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                     ovfFlag[c] <= 1'b0;
      else if (hitOvf[c])                            ovfFlag[c] <= 1'b1;
      else if (ctrlWr && armOvf && !wrData[BIT_OVF]) ovfFlag[c] <= 1'b0;
    end

    assign cmd[c].run     = runBits[c];
    assign cmd[c].divSel  = divSel[c];
    assign cmd[c].cntLoad = wrEn && (addr == A_CNT) && !runBits[c];
    assign cmd[c].cmpLoad = wrEn && (addr == A_CMP) && !runBits[c];
    assign ctrlWord[c]    = {divSel[c], intEn[c], modeBits[c], ovfFlag[c], matchFlag[c]};
    assign irq[c]         = matchFlag[c] & intEn[c];
  end

  always_comb begin
    rdData = '0;
    if (addr == '0) rdData[NCH-1:0] = runBits;
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(4*c + 4)) rdData = W'(ctrlWord[c]);
      if (addr == AW'(4*c + 5)) rdData = cntVal[c];
      if (addr == AW'(4*c + 6)) rdData = cmpVal[c];
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 32,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic           rdEn,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wrData,
  output logic [W-1:0]   rdData,
  output logic [NCH-1:0] irq
);
  chanCmd_t [NCH-1:0]    cmd;
  logic [NCH-1:0][W-1:0] cntVal;
  logic [NCH-1:0][W-1:0] cmpVal;
  logic [NCH-1:0]        hit, hitOvf;
  logic [NCH-1:0]        runBits, modeBits, matchFlag, ovfFlag;

  match_timer_ctrl #(.NCH(NCH), .W(W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .hit(hit), .hitOvf(hitOvf), .cntVal(cntVal),
    .cmpVal(cmpVal), .cmd(cmd), .rdData(rdData), .irq(irq),
    .runBits(runBits), .modeBits(modeBits), .matchFlag(matchFlag),
    .ovfFlag(ovfFlag)
  );

  match_timer_dp #(.NCH(NCH), .W(W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .cntVal(cntVal), .cmpVal(cmpVal), .hit(hit), .hitOvf(hitOvf)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int NCH = 2,
  parameter int W   = 32,
  parameter int AW  = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [AW-1:0]         addr,
  input logic [NCH-1:0]        runBits,
  input logic [NCH-1:0]        modeBits,
  input logic [NCH-1:0]        matchFlag,
  input logic [NCH-1:0]        ovfFlag,
  input logic [NCH-1:0]        hit,
  input logic [NCH-1:0]        hitOvf,
  input logic [NCH-1:0][W-1:0] cntVal
);
  logic startWr;
  assign startWr = wrEn && (addr == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic cntWr;
    assign cntWr = wrEn && (addr == AW'(4*c + 5));

    assert_oneshot_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
      hit[c] && !modeBits[c] && !startWr |=> !runBits[c] && cntVal[c] == '0);

    assert_periodic_runs_R4: assert property (@(posedge clk) disable iff (!rstN)
      hit[c] && modeBits[c] && !startWr |=> runBits[c] && cntVal[c] == '0);

    assert_ovf_sets_both_R5: assert property (@(posedge clk) disable iff (!rstN)
      hitOvf[c] |=> ovfFlag[c] && matchFlag[c]);

    assert_match_beats_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      hit[c] |=> matchFlag[c]);

    assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
      !runBits[c] && !cntWr |=> cntVal[c] == $past(cntVal[c]));
  end
endmodule

bind match_timer match_timer_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .runBits(runBits),
  .modeBits(modeBits), .matchFlag(matchFlag), .ovfFlag(ovfFlag),
  .hit(hit), .hitOvf(hitOvf), .cntVal(cntVal)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int W   = 32;
  localparam int AW  = 4;

  typedef struct packed {
    logic [1:0]  div;
    logic        mode;
    logic [7:0]  cmp;
    logic [15:0] waitN;
    logic [7:0]  expCnt;
    logic        expFlag;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd5, 16'd23,  8'd5, 1'b0},
    '{2'd0, 1'b0, 8'd5, 16'd24,  8'd0, 1'b1},
    '{2'd0, 1'b0, 8'd5, 16'd40,  8'd0, 1'b1},
    '{2'd1, 1'b1, 8'd3, 16'd32,  8'd0, 1'b1},
    '{2'd1, 1'b1, 8'd3, 16'd48,  8'd2, 1'b1},
    '{2'd2, 1'b1, 8'd2, 16'd47,  8'd2, 1'b0},
    '{2'd3, 1'b0, 8'd1, 16'd127, 8'd1, 1'b0},
    '{2'd3, 1'b0, 8'd1, 16'd200, 8'd0, 1'b1}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic           rdEn = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [W-1:0]   wrData = '0;
  logic [W-1:0]   rdData;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  match_timer #(.NCH(NCH), .W(W), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] aCtrl(input int ch); return AW'(4*ch + 4); endfunction
  function automatic logic [AW-1:0] aCnt(input int ch);  return AW'(4*ch + 5); endfunction
  function automatic logic [AW-1:0] aCmp(input int ch);  return AW'(4*ch + 6); endfunction
  function automatic logic [W-1:0] ctrlVal(input logic [1:0] div, input logic ien,
                                           input logic mode, input logic [1:0] flags);
    return W'({div, ien, mode, flags});
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic arm(input logic [AW-1:0] a);
    rdEn = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [W-1:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [1:0] div, input logic mode, input logic ien,
                       input logic [W-1:0] cmp, input logic [W-1:0] cnt);
    wr('0, '0);
    wr(aCnt(ch), cnt);
    wr(aCmp(ch), cmp);
    arm(aCtrl(ch));
    wr(aCtrl(ch), ctrlVal(div, ien, mode, 2'b00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, v2;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R11: reset values
    peek('0, v);       check("R11 start reg", v, '0);
    peek(aCnt(0), v);  check("R11 counter", v, '0);
    peek(aCmp(0), v);  check("R11 compare", v, 32'hFFFF_FFFF);
    peek(aCtrl(1), v); check("R11 ctrl word", v, '0);
    check("R11 irq", W'(irq), '0);

    // R1: configured but never started
    setup(1, 2'd0, 1'b1, 1'b0, 32'd3, 32'd7);
    waitN(40);
    peek(aCnt(1), v); check("R1 counter idle without start", v, 32'd7);

    // R2/R3/R4: vector table on channel 0
    for (int i = 0; i < NV; i++) begin
      setup(0, VECS[i].div, VECS[i].mode, 1'b0, W'(VECS[i].cmp), '0);
      wr('0, 32'd1);
      waitN(int'(VECS[i].waitN));
      peek(aCnt(0), v);
      check($sformatf("R2/R3/R4 vector %0d counter", i), v, W'(VECS[i].expCnt));
      peek(aCtrl(0), v);
      check($sformatf("R3/R4 vector %0d match flag", i), W'(v[0]), W'(VECS[i].expFlag));
      peek('0, v);
      check($sformatf("R3/R4 vector %0d start bit", i), W'(v[0]),
            W'(!(VECS[i].expFlag && !VECS[i].mode)));
    end

    // R5: overflow via all-ones compare
    setup(0, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
    wr('0, 32'd1);
    waitN(7);
    peek(aCnt(0), v);  check("R5 counter before wrap", v, 32'hFFFF_FFFF);
    peek(aCtrl(0), v); check("R5 flags before wrap", W'(v[1:0]), W'(2'b00));
    waitN(1);
    peek(aCnt(0), v);  check("R5 counter after wrap", v, '0);
    peek(aCtrl(0), v); check("R5 both flags set", W'(v[1:0]), W'(2'b11));

    // R6: flag clear handshake
    wr(aCtrl(0), ctrlVal(2'd0, 1'b0, 1'b0, 2'b00));
    peek(aCtrl(0), v); check("R6 write 0 without read keeps flags", W'(v[1:0]), W'(2'b11));
    arm(aCtrl(0));
    wr(aCtrl(0), ctrlVal(2'd0, 1'b0, 1'b0, 2'b11));
    peek(aCtrl(0), v); check("R6 write 1 keeps flags", W'(v[1:0]), W'(2'b11));
    arm(aCtrl(0));
    wr(aCtrl(0), ctrlVal(2'd0, 1'b0, 1'b0, 2'b00));
    peek(aCtrl(0), v); check("R6 read then write 0 clears", W'(v[1:0]), W'(2'b00));

    // R8/R10/R9: interrupt gating, writes while running, stop holds
    setup(0, 2'd0, 1'b1, 1'b0, 32'd1, '0);
    wr('0, 32'd1);
    waitN(8);
    peek(aCtrl(0), v); check("R8 flag set with enable off", W'(v[0]), 32'd1);
    check("R8 irq low with enable off", W'(irq[0]), '0);
    wr(aCtrl(0), ctrlVal(2'd3, 1'b1, 1'b0, 2'b11));
    peek(aCtrl(0), v); check("R10 config ignored while running", W'(v[5:2]), W'(4'b0001));
    check("R10 irq still low", W'(irq[0]), '0);
    wr(aCnt(0), 32'h55);
    peek(aCnt(0), v); check("R10 counter write ignored", W'(v <= 32'd1), 32'd1);
    wr(aCmp(0), 32'h77);
    peek(aCmp(0), v); check("R10 compare write ignored", v, 32'd1);
    wr('0, '0);
    peek(aCnt(0), v);
    waitN(20);
    peek(aCnt(0), v2); check("R9 stopped counter holds", v2, v);
    wr(aCtrl(0), ctrlVal(2'd0, 1'b1, 1'b1, 2'b11));
    check("R8 irq high with enable on", W'(irq[0]), 32'd1);

    // R7: match on the same edge as an armed clear
    setup(0, 2'd0, 1'b1, 1'b0, 32'd0, '0);
    wr('0, 32'd1);       // start at edge E0
    waitN(4);            // match at E4
    arm(aCtrl(0));       // armed at E5
    waitN(2);
    wr(aCtrl(0), '0);    // clear at E8, a match edge
    peek(aCtrl(0), v); check("R7 match wins over clear", W'(v[0]), 32'd1);
    arm(aCtrl(0));       // E9
    wr(aCtrl(0), '0);    // E10, no match
    peek(aCtrl(0), v); check("R6 clear off a match edge", W'(v[0]), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule